// File: doc/BRIEF.md
# Programmable Duty Pixel Clock Generator

This block produces the timing clock of a display controller from the bus clock in two stages. The first stage is a prescaler that makes a one-cycle enable strobe at the full, half or quarter bus rate. The second stage is a waveform shaper. It counts those strobes ("ticks") to drive a pixel-clock level, and the high phase and the low phase each have their own programmed length. The duty cycle is therefore free. The shaper also flags every rising edge of the level with a one-cycle strobe. The shaper enforces a minimum period of five ticks, and it takes new lengths only at the start of a high phase, so a reprogram never produces a runt pulse.

A single run enable controls both stages. When the enable is set, the block sends one init pulse to the rest of the controller and starts both clocks from a known phase. When the enable is cleared, both clocks stop and every output goes low. All pins are plain control and status levels or strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pxclk_gen`

## Requirements
- R1: While reset is asserted, and after its release until the enable is sampled high, all four outputs are low.
- R2: While running, `mid_ce_o` pulses for one bus cycle once every N cycles. N is 1 for select code 0, 2 for code 1, and 4 for both code 2 and code 3.
- R3: The pixel level stays high for H ticks. H is `hi_len_i`, except that a value of 0 counts as 1. The level changes only in the cycle after a tick.
- R4: The pixel level stays low for L ticks. L is `lo_len_i`, except that a value of 0 counts as 1.
- R5: When H+L is below 5, the low phase is stretched to 5−H ticks, so that every period is at least 5 ticks.
- R6: `pix_rise_o` is high for exactly one cycle: the first cycle in which `pix_o` is high after being low.
- R7: The enable is sampled high at clock edge k. The first tick is in the cycle after edge k+N−1, and `pix_o` rises after edge k+N. The enable is sampled low at some edge. From the next cycle, `pix_o`, `mid_ce_o` and `pix_rise_o` are low, and both stages restart from their initial phase.
- R8: `init_pulse_o` is high for one cycle, after the first edge at which the enable is sampled high. It stays low while the enable is held.
- R9: The high and low lengths are captured at each rising edge of the pixel level. A change made during a period takes effect at the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| run_en_i | input | 1 | Run enable for both clock stages |
| div_sel_i | input | 2 | Prescale select: 0 gives /1, 1 gives /2, 2 and 3 give /4 |
| hi_len_i | input | 6 | High-phase length in ticks (0 counts as 1) |
| lo_len_i | input | 6 | Low-phase length in ticks (0 counts as 1) |
| mid_ce_o | output | 1 | Prescaled clock enable (tick) |
| pix_o | output | 1 | Pixel clock level |
| pix_rise_o | output | 1 | One-cycle strobe on each rising pixel edge |
| init_pulse_o | output | 1 | One-cycle controller initialisation pulse |

## Verification
A prescaler counter that is stuck or wraps at the wrong value shows up within one period as a wrong spacing of `mid_ce_o`, and as high and low times scaled by the wrong factor. A wrong phase counter or wrong length capture in the shaper shows up at the next pixel edge as a phase of the wrong length. If lengths are captured mid-period, a phase of the new length appears one period too early. A start flag or enable register that is not cleared shows up on the first cycle after disable as a non-zero output, or on re-enable as a wrong first-edge latency or a missing init pulse.

// File: rtl/pxclk_pkg.sv
package pxclk_pkg;

  // Prescale select encoding; the last code is reserved and divides by 4.
  typedef enum logic [1:0] {
    DIV_BY_1   = 2'd0,
    DIV_BY_2   = 2'd1,
    DIV_BY_4   = 2'd2,
    DIV_BY_4_R = 2'd3
  } div_sel_e;

  localparam int unsigned LEN_W_DEF      = 6;
  localparam int unsigned MIN_PERIOD_DEF = 5;

endpackage

// File: rtl/pxclk_run_ctrl.sv
// Registers the run enable and forms the one-cycle init pulse on its rise.
module pxclk_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_en_i,
  output logic run_q_o,
  output logic init_o
);

  logic run_q;
  logic init_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      run_q  <= run_en_i;
      init_q <= run_en_i & ~run_q;
    end
  end

  assign run_q_o = run_q;
  assign init_o  = init_q;

endmodule

// File: rtl/pxclk_prescale.sv
// Divides the bus clock into a one-cycle tick every 1, 2 or 4 cycles.
module pxclk_prescale
  import pxclk_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       adv_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             at_term;

  always_comb begin
    unique case (div_sel_e'(sel_i))
      DIV_BY_1: term = CNT_W'(0);
      DIV_BY_2: term = CNT_W'(1);
      default:  term = CNT_W'(3);
    endcase
  end

  // ">=" lets a mid-run select change recover without a long wrap.
  assign at_term = (cnt_q >= term);
  assign tick_o  = adv_i & at_term;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= at_term ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pxclk_shaper.sv
// Shapes the pixel level from ticks with separately programmed phase lengths.
module pxclk_shaper #(
  parameter int unsigned LEN_W      = 6,
  parameter int unsigned MIN_PERIOD = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] hi_raw_i,
  input  logic [LEN_W-1:0] lo_raw_i,
  output logic             level_o,
  output logic             rise_o
);

  localparam int unsigned SUM_W = LEN_W + 1;

  logic [LEN_W-1:0] hi_fix, lo_fix, lo_min, lo_eff;
  logic [SUM_W-1:0] sum_fix;
  logic [LEN_W-1:0] cnt_q, hi_q, lo_q;
  logic             lvl_q, started_q, rise_q;
  logic             start_high, end_high;

  // Zero lengths count as one tick; short periods stretch the low phase.
  always_comb begin
    hi_fix  = (hi_raw_i == '0) ? LEN_W'(1) : hi_raw_i;
    lo_fix  = (lo_raw_i == '0) ? LEN_W'(1) : lo_raw_i;
    sum_fix = {1'b0, hi_fix} + {1'b0, lo_fix};
    lo_min  = LEN_W'(MIN_PERIOD) - hi_fix;
    lo_eff  = (sum_fix < SUM_W'(MIN_PERIOD)) ? lo_min : lo_fix;
  end

  assign start_high = tick_i & (~started_q | (~lvl_q & (cnt_q == lo_q - LEN_W'(1))));
  assign end_high   = tick_i & started_q & lvl_q & (cnt_q == hi_q - LEN_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      cnt_q     <= '0;
      hi_q      <= LEN_W'(1);
      lo_q      <= LEN_W'(1);
      lvl_q     <= 1'b0;
      started_q <= 1'b0;
      rise_q    <= 1'b0;
    end else begin
      rise_q <= start_high;
      if (start_high) begin
        lvl_q     <= 1'b1;
        cnt_q     <= '0;
        hi_q      <= hi_fix;
        lo_q      <= lo_eff;
        started_q <= 1'b1;
      end else if (end_high) begin
        lvl_q <= 1'b0;
        cnt_q <= '0;
      end else if (tick_i) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = rise_q;

endmodule

// File: rtl/pxclk_gen.sv
module pxclk_gen
  import pxclk_pkg::*;
#(
  parameter int unsigned LEN_W      = LEN_W_DEF,
  parameter int unsigned MIN_PERIOD = MIN_PERIOD_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic [1:0]       div_sel_i,
  input  logic [LEN_W-1:0] hi_len_i,
  input  logic [LEN_W-1:0] lo_len_i,
  output logic             mid_ce_o,
  output logic             pix_o,
  output logic             pix_rise_o,
  output logic             init_pulse_o
);

  logic run_q;
  logic tick;
  logic stop;

  assign stop = ~run_en_i;

  pxclk_run_ctrl u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_en_i (run_en_i),
    .run_q_o  (run_q),
    .init_o   (init_pulse_o)
  );

  pxclk_prescale #(.CNT_W(2)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (stop),
    .adv_i   (run_q),
    .sel_i   (div_sel_i),
    .tick_o  (tick)
  );

  pxclk_shaper #(.LEN_W(LEN_W), .MIN_PERIOD(MIN_PERIOD)) u_shp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (stop),
    .tick_i   (tick),
    .hi_raw_i (hi_len_i),
    .lo_raw_i (lo_len_i),
    .level_o  (pix_o),
    .rise_o   (pix_rise_o)
  );

  assign mid_ce_o = tick;

endmodule

// File: rtl/pxclk_checks.sv
module pxclk_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_en_i,
  input logic [1:0] div_sel_i,
  input logic       mid_ce_o,
  input logic       pix_o,
  input logic       pix_rise_o,
  input logic       init_pulse_o
);

  logic       seen1, seen2, armed;
  logic [6:0] tick_cnt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen1    <= 1'b0;
      seen2    <= 1'b0;
      armed    <= 1'b0;
      tick_cnt <= '0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
      if (!run_en_i) begin
        armed    <= 1'b0;
        tick_cnt <= '0;
      end else if (pix_rise_o) begin
        armed    <= 1'b1;
        tick_cnt <= {6'd0, mid_ce_o};
      end else if (mid_ce_o && tick_cnt != 7'h7f) begin
        tick_cnt <= tick_cnt + 7'd1;
      end
    end
  end

  AST_FULL_RATE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen1 && $past(run_en_i) && div_sel_i == 2'd0) |-> mid_ce_o); // R2

  AST_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen1 && $past(run_en_i) && pix_o != $past(pix_o)) |-> $past(mid_ce_o)); // R3

  AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_rise_o && armed) |-> tick_cnt >= 7'd5); // R5

  AST_RISE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen1 && pix_rise_o) |-> (pix_o && !$past(pix_o))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen1 && !$past(run_en_i)) |-> (!pix_o && !mid_ce_o && !pix_rise_o && !init_pulse_o)); // R7

  AST_INIT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen2 && init_pulse_o) |-> ($past(run_en_i) && !$past(run_en_i, 2))); // R8

  AST_INIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pulse_o |=> !init_pulse_o); // R8

endmodule

bind pxclk_gen pxclk_checks i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_en_i     (run_en_i),
  .div_sel_i    (div_sel_i),
  .mid_ce_o     (mid_ce_o),
  .pix_o        (pix_o),
  .pix_rise_o   (pix_rise_o),
  .init_pulse_o (init_pulse_o)
);

// File: tb/test_pxclk_gen.sv
`timescale 1ns/1ps
module test_pxclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [5:0] hi_len = 6'd1;
  logic [5:0] lo_len = 6'd1;
  logic       mid_ce, pix, pix_rise, init_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  pxclk_gen i_pxclk_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .run_en_i     (run_en),
    .div_sel_i    (div_sel),
    .hi_len_i     (hi_len),
    .lo_len_i     (lo_len),
    .mid_ce_o     (mid_ce),
    .pix_o        (pix),
    .pix_rise_o   (pix_rise),
    .init_pulse_o (init_pulse)
  );

  // {div, hi, lo, N, expected high ticks, expected low ticks}
  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 6'd3,  6'd4,  3'd1, 7'd3,  7'd4},
    {2'd1, 6'd2,  6'd2,  3'd2, 7'd2,  7'd3},
    {2'd2, 6'd0,  6'd0,  3'd4, 7'd1,  7'd4},
    {2'd3, 6'd1,  6'd1,  3'd4, 7'd1,  7'd4},
    {2'd0, 6'd10, 6'd0,  3'd1, 7'd10, 7'd1},
    {2'd1, 6'd63, 6'd63, 3'd2, 7'd63, 7'd63},
    {2'd0, 6'd1,  6'd6,  3'd1, 7'd1,  7'd6},
    {2'd0, 6'd0,  6'd3,  3'd1, 7'd1,  7'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Count samples while pix equals lvl; also counts ticks, rises and inits.
  task automatic phase_len(input logic lvl, output int len, inout int ticks,
                           inout int rises, inout int inits);
    len = 0;
    while (pix == lvl && len < 4000) begin
      len++;
      if (mid_ce) ticks++;
      if (pix_rise) rises++;
      if (init_pulse) inits++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int lat, hl, ll, ticks, rises, inits;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pix in reset", pix, 0);
    chk("R1 mid_ce in reset", mid_ce, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs idle after reset", {pix, mid_ce, pix_rise, init_pulse}, 0);

    for (int v = 0; v < NV; v++) begin
      int n, eh, el;
      {div_sel, hi_len, lo_len} = VEC[v][30:17];
      n  = int'(VEC[v][16:14]);
      eh = int'(VEC[v][13:7]);
      el = int'(VEC[v][6:0]);
      run_en = 1'b1;
      @(negedge clk);
      lat = 1;
      chk("R8 init after enable", init_pulse, 1);
      while (!pix && lat < 600) begin @(negedge clk); lat++; end
      chk("R7 first rise latency", lat, n + 1);
      chk("R6 rise strobe on first high", pix_rise, 1);
      ticks = 0; rises = 0; inits = 0;
      phase_len(1'b1, hl, ticks, rises, inits);
      phase_len(1'b0, ll, ticks, rises, inits);
      chk("R3 high time", hl, eh * n);
      chk("R4 R5 low time", ll, el * n);
      chk("R2 ticks per period", ticks, eh + el);
      chk("R6 one rise strobe per period", rises, 1);
      chk("R8 no repeat init", inits, 0);
      run_en = 1'b0;
      @(negedge clk);
      chk("R7 quiet after disable", {pix, mid_ce, pix_rise, init_pulse}, 0);
      repeat (2) @(negedge clk);
    end

    // R9: lengths changed inside a period apply from the next rising edge
    div_sel = 2'd0; hi_len = 6'd4; lo_len = 6'd4;
    run_en = 1'b1;
    lat = 0;
    while (!pix && lat < 100) begin @(negedge clk); lat++; end
    hi_len = 6'd2; lo_len = 6'd3;
    ticks = 0; rises = 0; inits = 0;
    phase_len(1'b1, hl, ticks, rises, inits);
    chk("R9 current high keeps old length", hl, 4);
    phase_len(1'b0, ll, ticks, rises, inits);
    chk("R9 current low keeps old length", ll, 4);
    phase_len(1'b1, hl, ticks, rises, inits);
    chk("R9 next high uses new length", hl, 2);
    phase_len(1'b0, ll, ticks, rises, inits);
    chk("R9 next low uses new length", ll, 3);

    // R2: select change while running, divide by 2 spacing
    div_sel = 2'd1;
    repeat (4) @(negedge clk);
    ticks = 0;
    for (int i = 0; i < 8; i++) begin
      if (mid_ce) ticks++;
      @(negedge clk);
    end
    chk("R2 divide-by-2 tick count in 8 cycles", ticks, 4);
    run_en = 1'b0;
    @(negedge clk);
    chk("R7 stop clears outputs", {pix, mid_ce, pix_rise}, 0);
    finish_run();
  end

endmodule